// File: doc/BRIEF.md
# Reset Cause and NMI Control Register

This block is an 8-bit control and status register on the CPU's register bus. When read, it reports the kind of reset that last completed (soft or hard) and whether the expansion-bus reset line is currently driven. It also reports which of three sources have flagged the pending non-maskable interrupt: a register write on the first NMI channel, a register write on the second NMI channel, or an I/O trap on the second channel. When written, it can request a soft or hard reset, raise either NMI channel, or clear the NMI and trap flags.

A single write both clears and triggers. A one in an NMI bit raises that channel and a zero clears its flag. When both reset bits are set, the hard reset takes precedence. NMI bits are locked while any NMI-capable master is busy. Writes tagged as coming from the display coprocessor may set NMI flags but never clear them. Reset requests leave as single-cycle pulses. The cause bits change only when the external reset generator reports completion, so software always sees the cause of a reset that has actually occurred.

Top module: `rstnmi_ctrl_reg`

## Requirements
- R1: When `rst` is high at a clock edge, the cause bits 1:0 and flag bits 4:2 become 0, and all four pulse outputs are 0 in the following cycle.
- R2: A write with data bit 1 set drives `hard_rst_pulse` high for exactly the cycle after the write. A write with bit 0 set and bit 1 clear does the same on `soft_rst_pulse`. When both bits are set, only `hard_rst_pulse` is raised.
- R3: The cause bits 1:0 change only on a clock edge where `reset_done` is high and a reset request is pending. They then read 2'b10 for a pending hard request or 2'b01 for a pending soft request. At most one of the two bits is ever set.
- R4: Read bit 7 always equals the `exp_rst_active` input.
- R5: A CPU write accepted while no master is busy loads bits 3 (second NMI channel) and 2 (first NMI channel) with the written values. A written 1 in bit 2 or bit 3 pulses `nmi_a_pulse` or `nmi_b_pulse` respectively in the next cycle.
- R6: A CPU write accepted while no master is busy clears the trap flag (bit 4) when data bit 4 is 0, and leaves it unchanged when data bit 4 is 1.
- R7: `trap_evt` high at a clock edge sets bit 4 at that edge. This holds even if the same edge carries a write that would clear it, and even while a master is busy.
- R8: While any bit of `busy_vec` is high, writes leave bits 4:2 unchanged and raise no NMI pulse, but still issue reset requests.
- R9: A write with `wr_copro` high ORs data bits 3:2 into the flags and can neither clear bits 4:2 nor set bit 4.
- R10: Read bits 6:5 are always 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| wr_copro | input | 1 | Marks the current write as coming from the display coprocessor |
| reg_rdata | output | 8 | Read data |
| reset_done | input | 1 | Reset generator reports that the requested reset has completed |
| exp_rst_active | input | 1 | Current state of the expansion-bus reset line |
| trap_evt | input | 1 | I/O-trap event, sets the trap flag |
| busy_vec | input | N_BUSY | One bit per NMI-capable master that is currently active |
| soft_rst_pulse | output | 1 | Single-cycle soft reset request |
| hard_rst_pulse | output | 1 | Single-cycle hard reset request |
| nmi_a_pulse | output | 1 | Single-cycle request on the first NMI channel |
| nmi_b_pulse | output | 1 | Single-cycle request on the second NMI channel |

## Verification
The bench writes both reset bits together and checks that only the hard pulse appears. A design without the precedence would fire both requests or the soft one. It asserts `reset_done` with no request pending and also delays it after a request. A design that loads the cause on the write, or on a completion with nothing pending, would show a cause for a reset that never happened. It places a trap event on the same edge as a clearing write, and sends zero-writes both while a master is busy and from the coprocessor. A design with the wrong priority or gating would lose the trap flag or drop an NMI flag that software still needs.

// File: rtl/rstnmi_pkg.sv
package rstnmi_pkg;

    localparam int REG_W = 8;

    // Field positions of the register (read and write share them).
    localparam int BIT_SOFT  = 0;
    localparam int BIT_HARD  = 1;
    localparam int BIT_NMIA  = 2;
    localparam int BIT_NMIB  = 3;
    localparam int BIT_TRAP  = 4;
    localparam int BIT_EXPRS = 7;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_SOFT = 2'd1,
        KIND_HARD = 2'd2
    } rst_kind_e;

    typedef struct packed {
        logic trap;
        logic nmi_b;
        logic nmi_a;
    } nmi_flags_t;

    // Reset kind requested by a write; hard outranks soft.
    function automatic rst_kind_e f_req_kind(input logic [REG_W-1:0] wd);
        if (wd[BIT_HARD])      return KIND_HARD;
        else if (wd[BIT_SOFT]) return KIND_SOFT;
        else                   return KIND_NONE;
    endfunction

    // Cause bits loaded when a pending reset completes.
    function automatic logic [1:0] f_cause_bits(input rst_kind_e k);
        case (k)
            KIND_HARD: return 2'b10;
            KIND_SOFT: return 2'b01;
            default:   return 2'b00;
        endcase
    endfunction

    // Flag update for an accepted write.
    function automatic nmi_flags_t f_flags_after_write(
        input nmi_flags_t       cur,
        input logic [REG_W-1:0] wd,
        input logic             copro
    );
        nmi_flags_t nf;
        if (copro) begin
            nf.trap  = cur.trap;
            nf.nmi_b = cur.nmi_b | wd[BIT_NMIB];
            nf.nmi_a = cur.nmi_a | wd[BIT_NMIA];
        end else begin
            nf.trap  = cur.trap & wd[BIT_TRAP];
            nf.nmi_b = wd[BIT_NMIB];
            nf.nmi_a = wd[BIT_NMIA];
        end
        return nf;
    endfunction

endpackage

// File: rtl/rstnmi_cause_unit.sv
module rstnmi_cause_unit
    import rstnmi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wdata,
    input  logic             reset_done,
    output logic [1:0]       cause,
    output logic             soft_pulse,
    output logic             hard_pulse
);
    rst_kind_e req_kind;
    rst_kind_e pend_q;

    assign req_kind = wr_stb ? f_req_kind(wdata) : KIND_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= KIND_NONE;
            cause      <= 2'b00;
            soft_pulse <= 1'b0;
            hard_pulse <= 1'b0;
        end else begin
            soft_pulse <= (req_kind == KIND_SOFT);
            hard_pulse <= (req_kind == KIND_HARD);
            if (reset_done && pend_q != KIND_NONE)
                cause <= f_cause_bits(pend_q);
            if (req_kind != KIND_NONE)
                pend_q <= req_kind;
            else if (reset_done)
                pend_q <= KIND_NONE;
        end
    end
endmodule

// File: rtl/rstnmi_flag_unit.sv
module rstnmi_flag_unit
    import rstnmi_pkg::*;
#(
    parameter int N_BUSY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [REG_W-1:0]  wdata,
    input  logic              copro,
    input  logic [N_BUSY-1:0] busy_vec,
    input  logic              trap_evt,
    output nmi_flags_t        flags,
    output logic              nmi_a_pulse,
    output logic              nmi_b_pulse
);
    logic       accept;
    nmi_flags_t nxt;

    assign accept = wr_stb && !(|busy_vec);

    always_comb begin
        nxt = flags;
        if (accept)
            nxt = f_flags_after_write(flags, wdata, copro);
        if (trap_evt)
            nxt.trap = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags       <= '0;
            nmi_a_pulse <= 1'b0;
            nmi_b_pulse <= 1'b0;
        end else begin
            flags       <= nxt;
            nmi_a_pulse <= accept && wdata[BIT_NMIA];
            nmi_b_pulse <= accept && wdata[BIT_NMIB];
        end
    end
endmodule

// File: rtl/rstnmi_ctrl_reg.sv
module rstnmi_ctrl_reg
    import rstnmi_pkg::*;
#(
    parameter int N_BUSY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              wr_copro,
    output logic [7:0]        reg_rdata,
    input  logic              reset_done,
    input  logic              exp_rst_active,
    input  logic              trap_evt,
    input  logic [N_BUSY-1:0] busy_vec,
    output logic              soft_rst_pulse,
    output logic              hard_rst_pulse,
    output logic              nmi_a_pulse,
    output logic              nmi_b_pulse
);
    logic [1:0] cause;
    nmi_flags_t flags;

    rstnmi_cause_unit u_cause (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (reg_wr),
        .wdata      (reg_wdata),
        .reset_done (reset_done),
        .cause      (cause),
        .soft_pulse (soft_rst_pulse),
        .hard_pulse (hard_rst_pulse)
    );

    rstnmi_flag_unit #(.N_BUSY(N_BUSY)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (reg_wr),
        .wdata       (reg_wdata),
        .copro       (wr_copro),
        .busy_vec    (busy_vec),
        .trap_evt    (trap_evt),
        .flags       (flags),
        .nmi_a_pulse (nmi_a_pulse),
        .nmi_b_pulse (nmi_b_pulse)
    );

    always_comb begin
        reg_rdata                         = '0;
        reg_rdata[BIT_EXPRS]              = exp_rst_active;
        reg_rdata[BIT_TRAP]               = flags.trap;
        reg_rdata[BIT_NMIB]               = flags.nmi_b;
        reg_rdata[BIT_NMIA]               = flags.nmi_a;
        reg_rdata[BIT_HARD:BIT_SOFT]      = cause;
    end
endmodule

// File: rtl/rstnmi_ctrl_chk.sv
module rstnmi_ctrl_chk #(
    parameter int N_BUSY = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic              wr_copro,
    input logic [7:0]        reg_rdata,
    input logic              reset_done,
    input logic              exp_rst_active,
    input logic              trap_evt,
    input logic [N_BUSY-1:0] busy_vec,
    input logic              soft_rst_pulse,
    input logic              hard_rst_pulse,
    input logic              nmi_a_pulse,
    input logic              nmi_b_pulse
);
    // R2: hard and soft requests never fire together
    a_r2_one_request: assert property (@(posedge clk) disable iff (rst)
        !(soft_rst_pulse && hard_rst_pulse));

    // R2: a hard pulse follows a write with bit 1 set
    a_r2_hard_source: assert property (@(posedge clk) disable iff (rst)
        hard_rst_pulse |-> $past(reg_wr && reg_wdata[1]));

    // R3: cause bits are one-hot or zero
    a_r3_cause_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_rdata[1:0]));

    // R3: cause bits hold unless completion is reported
    a_r3_cause_hold: assert property (@(posedge clk) disable iff (rst)
        !reset_done |=> $stable(reg_rdata[1:0]));

    // R4: bit 7 tracks the expansion-bus reset line
    a_r4_bus_line: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] == exp_rst_active);

    // R7: a trap event sets bit 4
    a_r7_trap_sets: assert property (@(posedge clk) disable iff (rst)
        trap_evt |=> reg_rdata[4]);

    // R8: busy masters lock the flags and suppress NMI pulses
    a_r8_busy_lock: assert property (@(posedge clk) disable iff (rst)
        (|busy_vec && !trap_evt) |=> ($stable(reg_rdata[4:2]) && !nmi_a_pulse && !nmi_b_pulse));

    // R9: coprocessor writes never clear a flag
    a_r9_copro_noclear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wr_copro) |=> ((reg_rdata[4:2] & $past(reg_rdata[4:2])) == $past(reg_rdata[4:2])));

    // R10: reserved bits read zero
    a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6:5] == 2'b00);
endmodule

bind rstnmi_ctrl_reg rstnmi_ctrl_chk #(.N_BUSY(N_BUSY)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .wr_copro       (wr_copro),
    .reg_rdata      (reg_rdata),
    .reset_done     (reset_done),
    .exp_rst_active (exp_rst_active),
    .trap_evt       (trap_evt),
    .busy_vec       (busy_vec),
    .soft_rst_pulse (soft_rst_pulse),
    .hard_rst_pulse (hard_rst_pulse),
    .nmi_a_pulse    (nmi_a_pulse),
    .nmi_b_pulse    (nmi_b_pulse)
);

// File: tb/test_rstnmi_ctrl_reg.sv
`timescale 1ns/1ps
module test_rstnmi_ctrl_reg;
    localparam int N_BUSY = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr;
    logic [7:0]        reg_wdata;
    logic              wr_copro;
    logic [7:0]        reg_rdata;
    logic              reset_done;
    logic              exp_rst_active;
    logic              trap_evt;
    logic [N_BUSY-1:0] busy_vec;
    logic              soft_rst_pulse, hard_rst_pulse, nmi_a_pulse, nmi_b_pulse;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    rstnmi_ctrl_reg #(.N_BUSY(N_BUSY)) i_rstnmi_ctrl_reg (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .wr_copro(wr_copro), .reg_rdata(reg_rdata), .reset_done(reset_done),
        .exp_rst_active(exp_rst_active), .trap_evt(trap_evt), .busy_vec(busy_vec),
        .soft_rst_pulse(soft_rst_pulse), .hard_rst_pulse(hard_rst_pulse),
        .nmi_a_pulse(nmi_a_pulse), .nmi_b_pulse(nmi_b_pulse)
    );

    // Pulse vector order: {hard, soft, nmi_b, nmi_a}
    typedef struct packed {
        logic       wr;
        logic       cp;
        logic [3:0] busy;
        logic       trap;
        logic       done;
        logic       ext;
        logic [7:0] wd;
        logic [7:0] exp_rd;
        logic [3:0] exp_p;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,8'h00,8'h00,4'b0000,8'd1 },  // R1 idle after reset
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b1,8'h00,8'h80,4'b0000,8'd4 },  // R4 bus line
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h02,8'h00,4'b1000,8'd2 },  // R2 hard request
        '{1'b0,1'b0,4'h0,1'b0,1'b1,1'b0,8'h00,8'h02,4'b0000,8'd3 },  // R3 hard completes
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h01,8'h02,4'b0100,8'd2 },  // R2 soft request
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,8'h00,8'h02,4'b0000,8'd3 },  // R3 not yet done
        '{1'b0,1'b0,4'h0,1'b0,1'b1,1'b0,8'h00,8'h01,4'b0000,8'd3 },  // R3 soft completes
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h03,8'h01,4'b1000,8'd2 },  // R2 both -> hard
        '{1'b0,1'b0,4'h0,1'b0,1'b1,1'b0,8'h00,8'h02,4'b0000,8'd3 },  // R3 hard completes
        '{1'b0,1'b0,4'h0,1'b0,1'b1,1'b0,8'h00,8'h02,4'b0000,8'd3 },  // R3 done, none pending
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h04,8'h06,4'b0001,8'd5 },  // R5 raise channel A
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h0C,8'h0E,4'b0011,8'd5 },  // R5 raise both
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h00,8'h02,4'b0000,8'd5 },  // R5 clear both
        '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,8'h00,8'h12,4'b0000,8'd7 },  // R7 trap sets
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h10,8'h12,4'b0000,8'd6 },  // R6 one keeps trap
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h00,8'h02,4'b0000,8'd6 },  // R6 zero clears trap
        '{1'b1,1'b0,4'h0,1'b1,1'b0,1'b0,8'h00,8'h12,4'b0000,8'd7 },  // R7 trap beats clear
        '{1'b1,1'b0,4'h1,1'b0,1'b0,1'b0,8'h0C,8'h12,4'b0000,8'd8 },  // R8 busy blocks set
        '{1'b1,1'b0,4'h8,1'b0,1'b0,1'b0,8'h00,8'h12,4'b0000,8'd8 },  // R8 busy blocks clear
        '{1'b1,1'b0,4'h4,1'b0,1'b0,1'b0,8'h02,8'h12,4'b1000,8'd8 },  // R8 reset still issued
        '{1'b1,1'b1,4'h0,1'b0,1'b0,1'b0,8'h04,8'h16,4'b0001,8'd9 },  // R9 copro sets
        '{1'b1,1'b1,4'h0,1'b0,1'b0,1'b0,8'h00,8'h16,4'b0000,8'd9 },  // R9 copro zero keeps
        '{1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,8'h60,8'h02,4'b0000,8'd10},  // R10 reserved read 0
        '{1'b0,1'b0,4'h2,1'b1,1'b0,1'b0,8'h00,8'h12,4'b0000,8'd7 }   // R7 trap while busy
    };

    task automatic chk8(input string what, input int rq, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    function automatic logic [3:0] pulses();
        return {hard_rst_pulse, soft_rst_pulse, nmi_b_pulse, nmi_a_pulse};
    endfunction

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_wdata = '0; wr_copro = 1'b0; reset_done = 1'b0;
        exp_rst_active = 1'b0; trap_evt = 1'b0; busy_vec = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk8("reset rdata", 1, reg_rdata, 8'h00);
        chk8("reset pulses", 1, {4'h0, pulses()}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            reg_wr = VEC[i].wr; wr_copro = VEC[i].cp; busy_vec = VEC[i].busy;
            trap_evt = VEC[i].trap; reset_done = VEC[i].done;
            exp_rst_active = VEC[i].ext; reg_wdata = VEC[i].wd;
            @(negedge clk);
            chk8($sformatf("vec %0d rdata", i), int'(VEC[i].req), reg_rdata, VEC[i].exp_rd);
            chk8($sformatf("vec %0d pulses", i), int'(VEC[i].req), {4'h0, pulses()}, {4'h0, VEC[i].exp_p});
        end

        // R2: pulse lasts one cycle only
        idle_inputs();
        @(negedge clk);
        chk8("pulses drop", 2, {4'h0, pulses()}, 8'h00);

        // R3: pending hard from busy-cycle write completes
        reset_done = 1'b1;
        @(negedge clk);
        reset_done = 1'b0;
        chk8("late hard completion", 3, {6'h0, reg_rdata[1:0]}, 8'h02);

        // R3: soft request, done on the same edge as a new hard request
        reg_wr = 1'b1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wdata = 8'h02; reset_done = 1'b1;
        @(negedge clk);
        chk8("done with new request", 3, {6'h0, reg_rdata[1:0]}, 8'h01);
        reg_wr = 1'b0; reset_done = 1'b1;
        @(negedge clk);
        reset_done = 1'b0;
        chk8("newer request completes", 3, {6'h0, reg_rdata[1:0]}, 8'h02);

        // R1: mid-run reset clears cause and flags
        trap_evt = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h0C;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk8("mid reset rdata", 1, reg_rdata, 8'h00);
        chk8("mid reset pulses", 1, {4'h0, pulses()}, 8'h00);

        finish_run();
    end
endmodule